// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward a processor. Each line is brought into the clock domain through a two-stage synchronizer. A rising edge on the synchronized line sets a pending bit. The controller takes the lowest-numbered pending line that is not masked and is not excluded by a programmable threshold, and asserts `int_out` whenever such a line exists. Line 0 has the highest priority and line 7 the lowest.

When the processor pulses `ack`, the controller returns a vector one cycle later:

- **Normal acknowledge:** if the chosen line is still high at its synchronized level, the vector is `base + index` and the line's in-service bit is set.
- **Spurious acknowledge:** if the chosen line is no longer high, or nothing was eligible, the vector is the spurious code `base + 7` and no in-service bit is set.

The in-service bits allow nesting. A request is forwarded only if its priority is strictly higher than the highest-priority in-service line. Lower, equal or repeated requests stay pending. They are delivered in priority order once `eos` pulses, which retires the highest-priority in-service bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are 0, no line is pending or in service, the mask is all zeros, the threshold is 7 and the vector base is 0x40.
- R2: A 0-to-1 transition on `irq_in[i]`, applied before a clock edge, sets pending bit i at the third edge. `int_out` rises after that third edge if line i is eligible. A line that stays high sets pending only once.
- R3: Among eligible lines the lowest index wins. On `ack`, a normal vector equals `base + index` (8-bit wrap), and that line's pending bit is cleared.
- R4: A line whose mask bit is 1 (`mask_d` bit i, loaded by `mask_we`) is never forwarded while masked. It stays pending and is forwarded once unmasked.
- R5: A line whose index is greater than the threshold (`thr_d`, loaded by `thr_we`) is not forwarded.
- R6: When lines are in service, only a pending line with index strictly less than the lowest in-service index is forwarded. Lower, equal or repeated requests stay pending.
- R7: An `eos` pulse clears the lowest-index set in-service bit. It has no effect when nothing is in service. Requests held by that bit then become eligible in priority order.
- R8: If the chosen line's synchronized level is 0 at `ack`, the vector is `base + 7`, no in-service bit is set, and the chosen line's pending bit is cleared.
- R9: An `ack` while `int_out` is 0 returns `base + 7` and changes no pending or in-service state.
- R10: `vec_valid` is high exactly in the cycle after an `ack` cycle, and `vec_out` then holds the vector for that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Asynchronous request lines, bit 0 highest priority |
| mask_we | input | 1 | Load mask register |
| mask_d | input | 8 | Mask value, 1 blocks a line |
| thr_we | input | 1 | Load threshold |
| thr_d | input | 3 | Highest line index still allowed |
| base_we | input | 1 | Load vector base |
| base_d | input | 8 | Vector base |
| ack | input | 1 | Processor acknowledge pulse |
| eos | input | 1 | End of service pulse |
| int_out | output | 1 | Interrupt request to processor |
| vec_valid | output | 1 | Vector valid, one cycle after ack |
| vec_out | output | 8 | Returned vector |

## Verification
The hardest state to reach is deep nesting with held requests. Several lines must be in service at once, while lower and equal-priority edges wait behind them and are later released one `eos` at a time. A directed sequence builds this state by raising and dropping lines around each acknowledge. The spurious case requires a line to be latched and then dropped for at least two cycles before `ack`, and the directed test does exactly that. Long random runs then mix toggling lines with acks, `eos` pulses and mask, threshold and base writes, and compare every cycle against a bench model.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N  = 8,
  parameter int VW = 8,
  parameter logic [VW-1:0] BASE_RST = 8'h40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         irq_in,
  input  logic                 mask_we,
  input  logic [N-1:0]         mask_d,
  input  logic                 thr_we,
  input  logic [$clog2(N)-1:0] thr_d,
  input  logic                 base_we,
  input  logic [VW-1:0]        base_d,
  input  logic                 ack,
  input  logic                 eos,
  output logic                 int_out,
  output logic                 vec_valid,
  output logic [VW-1:0]        vec_out
);
  localparam int IW  = $clog2(N);
  localparam int IW1 = IW + 1;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  s1, s2, s3, pend, isr, mask, elig, cand_oh, isr_low;
  logic [IW-1:0] thr, cand_idx;
  logic [IW1-1:0] isr_top;
  logic [VW-1:0] base;
  logic          ack_hit, ack_real;

  wire [N-1:0] rise = s2 & ~s3;

  always_comb begin
    isr_top = IW1'(N);
    for (int i = N - 1; i >= 0; i--)
      if (isr[i]) isr_top = IW1'(i);
    for (int i = 0; i < N; i++)
      elig[i] = pend[i] & ~mask[i] & (IW'(i) <= thr) & (IW1'(i) < isr_top);
    cand_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (elig[i]) cand_idx = IW'(i);
  end

  assign cand_oh  = elig & (~elig + ONE);
  assign isr_low  = isr & (~isr + ONE);
  assign int_out  = |elig;
  assign ack_hit  = ack & int_out;
  assign ack_real = ack_hit & |(cand_oh & s2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      pend <= '0; isr <= '0; mask <= '0;
      thr <= IW'(N - 1); base <= BASE_RST;
      vec_valid <= 1'b0; vec_out <= '0;
    end else begin
      s1 <= irq_in; s2 <= s1; s3 <= s2;
      pend <= (pend & ~(ack_hit ? cand_oh : '0)) | rise;
      isr  <= (isr & ~(eos ? isr_low : '0)) | (ack_real ? cand_oh : '0);
      if (mask_we) mask <= mask_d;
      if (thr_we)  thr  <= thr_d;
      if (base_we) base <= base_d;
      vec_valid <= ack;
      if (ack) vec_out <= ack_real ? base + VW'(cand_idx) : base + VW'(N - 1);
    end
  end

  p_vec_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);
  p_vec_only_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));
  p_no_isr_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ($countones(isr) <= $past($countones(isr))));
  p_eos_retires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !ack && isr != '0) |=> ($countones(isr) == $past($countones(isr)) - 1));
  p_idle_ack_keeps_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !eos) |=> $stable(isr));
  p_masked_never_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> |(pend & ~mask));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] irq_in = '0, mask_d = '0, base_d = '0;
  logic [2:0] thr_d = '0;
  logic mask_we = 0, thr_we = 0, base_we = 0, ack = 0, eos = 0;
  logic int_out, vec_valid;
  logic [7:0] vec_out;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  logic [7:0] m_s1, m_s2, m_s3, m_pend, m_isr, m_mask, m_base, m_vec;
  logic [2:0] m_thr;
  logic m_vv;

  function automatic int pick(logic [7:0] p, logic [7:0] mk, logic [2:0] th, logic [7:0] is);
    int top = 8;
    for (int i = 7; i >= 0; i--) if (is[i]) top = i;
    for (int i = 0; i < 8; i++)
      if (p[i] && !mk[i] && i <= int'(th) && i < top) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pend = 0; m_isr = 0; m_mask = 0;
    m_thr = 7; m_base = 8'h40; m_vv = 0; m_vec = 0;
  endtask

  task automatic step();
    int c;
    logic [7:0] np, ni, nv, lvl;
    c = pick(m_pend, m_mask, m_thr, m_isr);
    np = m_pend; ni = m_isr; nv = m_vec; lvl = irq_in;
    if (eos) begin
      for (int i = 0; i < 8; i++) if (m_isr[i]) begin ni[i] = 0; break; end
    end
    if (ack) begin
      nv = m_base + 8'd7;
      if (c >= 0) begin
        np[c] = 0;
        if (m_s2[c]) begin ni[c] = 1; nv = m_base + 8'(c); end
      end
    end
    np = np | (m_s2 & ~m_s3);
    @(posedge clk);
    m_pend = np; m_isr = ni; m_vv = ack; m_vec = nv;
    if (mask_we) m_mask = mask_d;
    if (thr_we) m_thr = thr_d;
    if (base_we) m_base = base_d;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = lvl;
    @(negedge clk);
    chk(int_out == (pick(m_pend, m_mask, m_thr, m_isr) >= 0), {tag, " int_out"},
        int_out, pick(m_pend, m_mask, m_thr, m_isr) >= 0);
    chk(vec_valid == m_vv, {tag, " vec_valid R10"}, vec_valid, m_vv);
    if (m_vv) chk(vec_out == m_vec, {tag, " vector"}, vec_out, m_vec);
    ack = 0; eos = 0; mask_we = 0; thr_we = 0; base_we = 0;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic do_ack(input logic [7:0] exp_v, input string t);
    ack = 1; step();
    chk(vec_out == exp_v, t, vec_out, exp_v);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk(int_out == 0, "R1 int_out after reset", int_out, 0);
    chk(vec_valid == 0, "R1 vec_valid after reset", vec_valid, 0);
    ack = 1; step();
    chk(vec_out == 8'h47, "R1 base reset value", vec_out, 8'h47);

    tag = "R2";
    irq_in[5] = 1;
    step(); chk(int_out == 0, "R2 edge 1", int_out, 0);
    step(); chk(int_out == 0, "R2 edge 2", int_out, 0);
    step(); chk(int_out == 1, "R2 edge 3", int_out, 1);
    steps(4);
    tag = "R3";
    do_ack(8'h45, "R3 vector line 5");
    steps(5);
    chk(int_out == 0, "R2 held line sets pending once", int_out, 0);
    irq_in[5] = 0; eos = 1; step(); steps(3);

    tag = "R3";
    irq_in[6] = 1; irq_in[3] = 1; steps(4);
    do_ack(8'h43, "R3 lowest index wins");
    irq_in[3] = 0;
    chk(int_out == 0, "R6 line 6 held behind 3", int_out, 0);
    tag = "R6";
    irq_in[1] = 1; steps(4);
    chk(int_out == 1, "R6 higher preempts", int_out, 1);
    do_ack(8'h41, "R6 nested vector");
    irq_in[1] = 0;
    irq_in[2] = 1; steps(4);
    chk(int_out == 0, "R6 line 2 held behind 1", int_out, 0);
    irq_in[3] = 1; steps(4);
    tag = "R7";
    eos = 1; step();
    chk(int_out == 1, "R7 eos releases line 2", int_out, 1);
    do_ack(8'h42, "R7 release order 2");
    irq_in[2] = 0;
    eos = 1; step();
    chk(int_out == 0, "R6 equal line 3 held", int_out, 0);
    eos = 1; step();
    do_ack(8'h43, "R7 release order 3");
    irq_in[3] = 0; eos = 1; step();
    do_ack(8'h46, "R7 release order 6");
    irq_in[6] = 0; eos = 1; step();
    eos = 1; step();
    chk(int_out == 0, "R7 eos when empty", int_out, 0);

    tag = "R4";
    mask_d = 8'h02; mask_we = 1; step();
    irq_in[1] = 1; steps(5);
    chk(int_out == 0, "R4 masked line blocked", int_out, 0);
    mask_d = 0; mask_we = 1; step();
    chk(int_out == 1, "R4 unmasked forwards", int_out, 1);
    do_ack(8'h41, "R4 vector");
    irq_in[1] = 0; eos = 1; step();

    tag = "R5";
    thr_d = 3'd2; thr_we = 1; step();
    irq_in[3] = 1; steps(5);
    chk(int_out == 0, "R5 below threshold blocked", int_out, 0);
    thr_d = 3'd3; thr_we = 1; step();
    chk(int_out == 1, "R5 at threshold allowed", int_out, 1);
    do_ack(8'h43, "R5 vector");
    irq_in[3] = 0; eos = 1; step();
    thr_d = 3'd7; thr_we = 1; step();

    tag = "R8";
    irq_in[0] = 1; steps(4);
    irq_in[0] = 0; steps(3);
    chk(int_out == 1, "R8 pending survives drop", int_out, 1);
    do_ack(8'h47, "R8 spurious vector");
    chk(int_out == 0, "R8 pending cleared", int_out, 0);
    irq_in[4] = 1; steps(4);
    do_ack(8'h44, "R8 no in-service left by spurious");
    irq_in[4] = 0; eos = 1; step();

    tag = "R9";
    steps(3);
    do_ack(8'h47, "R9 idle ack");
    chk(int_out == 0, "R9 idle ack no state", int_out, 0);

    tag = "R3 base";
    base_d = 8'h80; base_we = 1; step();
    irq_in[2] = 1; steps(4);
    do_ack(8'h82, "R3 new base");
    irq_in[2] = 0; eos = 1; step();

    tag = "R6/R7 random";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(3) == 0) irq_in[$urandom_range(7)] ^= 1'b1;
      ack = ($urandom_range(5) == 0);
      eos = ($urandom_range(7) == 0);
      if ($urandom_range(63) == 0) begin mask_d = 8'($urandom); mask_we = 1; end
      if ($urandom_range(63) == 0) begin thr_d = 3'($urandom); thr_we = 1; end
      if ($urandom_range(255) == 0) begin base_d = 8'($urandom); base_we = 1; end
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule